// File: doc/BRIEF.md
# Power-Down Wake Controller

This block owns the power-down state of a small microcontroller core. Software sets a power-down bit through a one-cycle request. While that bit is set, the controller stops the oscillator and gates the CPU and peripheral clocks. It then decides how the core comes back. There are two wake paths:

- **Interrupt path.** An enabled, level-configured, active-low interrupt line wakes the core. Execution starts only after the oscillator has settled and the interrupt line has gone high again. RAM stays accessible throughout.
- **Reset path.** The reset pin clears the power-down bit at once, with no clock edge. After the oscillator restarts, the CPU runs for a short window with internal RAM access blocked. The block then raises a reset request that the core uses to reinitialise its registers and jump to address zero.

The controller steps through three visible phases: power-down, oscillator restart and active. An internal counter models oscillator settling, and an external oscillator-stable flag must also be high before the restart phase can end. Inputs are treated as synchronous to `clk_i`, except the reset pin, which clears the power-down bit asynchronously.

Top module: `pd_wake_ctrl`

## Requirements
- R1: After `rst_ni` is released, `pd_bit_o`=0, `osc_en_o`=1, `clk_en_o`=1, `cpu_resume_o`=1, `rst_req_o`=0, `ram_block_o`=0 and `phase_o`=0 (0 = active, 1 = power-down, 2 = oscillator restart).
- R2: `pd_set_i` high in the active phase sets `pd_bit_o` at the next clock edge. This enters phase 1 with `osc_en_o`, `clk_en_o` and `cpu_resume_o` all low.
- R3: In phase 1, a line i wakes the core when `irq_ni[i]`=0, `irq_en_i[i]`=1 and `irq_edge_i[i]`=0 (0 = level mode). At the next edge `pd_bit_o` clears, `phase_o` becomes 2, `osc_en_o` is 1 and `clk_en_o` stays 0.
- R4: A low line that is disabled, or that has `irq_edge_i[i]`=1, leaves `pd_bit_o`=1 and `phase_o`=1.
- R5: Phase 2 lasts exactly `STAB_CYCLES` cycles when `osc_stable_i` is high. While `osc_stable_i` is low it lasts longer. Leaving phase 2 sets `clk_en_o`=1.
- R6: After an interrupt wake, `cpu_resume_o` stays 0 in the active phase until the waking level is sampled released. It rises at the edge after release, or on entry to phase 0 if the release came during phase 2.
- R7: `ram_block_o` stays 0 along the whole interrupt wake path.
- R8: `rst_pin_i` high during phase 1 clears `pd_bit_o` and sets `osc_en_o` without waiting for a clock edge.
- R9: After a reset wake, `ram_block_o` is 1 from the first restart cycle onward. After phase 2, `cpu_resume_o`=1 for `WIN_CYCLES` cycles with `rst_req_o`=0, and then `rst_req_o` rises.
- R10: `rst_req_o` stays high for at least `RST_MIN_CYCLES` cycles and for as long as `rst_pin_i` is high. When it falls, `ram_block_o` returns to 0 and `cpu_resume_o` to 1.
- R11: `pd_set_i` issued while a wake-qualified line is already low gives exactly one cycle of phase 1, followed by phase 2.
- R12: When `rst_pin_i` and a qualified interrupt arrive in the same phase-1 cycle, the reset path is taken (`ram_block_o`=1).
- R13: `pd_set_i` outside the active phase is ignored (`pd_bit_o` stays 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous block reset |
| pd_set_i | input | 1 | Software request to set the power-down bit |
| irq_ni | input | N_IRQ | Active-low external interrupt lines |
| irq_en_i | input | N_IRQ | Per-line interrupt enable |
| irq_edge_i | input | N_IRQ | Per-line mode, 1 = edge, 0 = level |
| rst_pin_i | input | 1 | Active-high reset pin |
| osc_stable_i | input | 1 | Oscillator reports a stable output |
| osc_stable_i | input | 1 | Oscillator reports a stable output |
| pd_bit_o | output | 1 | Power-down bit |
| phase_o | output | 2 | 0 active, 1 power-down, 2 oscillator restart |
| osc_en_o | output | 1 | Oscillator enable |
| clk_en_o | output | 1 | CPU and peripheral clock enable |
| cpu_resume_o | output | 1 | CPU may execute |
| rst_req_o | output | 1 | Internal reset request to the core |
| ram_block_o | output | 1 | Blocks internal RAM access |

## Verification
The embedded properties check several rules on every cycle:
- the power-down bit only exists in the power-down phase;
- no unqualified line can end power-down;
- the reset pin never coexists with a set bit;
- the reset path wins a tie;
- the reset request never lasts a single cycle;
- the CPU never resumes while a waking level is still low;
- the interrupt path never blocks RAM.

Only the bench scenarios show the exact restart and window lengths, the asynchronous clear between edges, the single-cycle power-down on an already-pending interrupt, and the full sequence of resume, RAM block and reset request across a reset wake.

// File: rtl/pd_wake_pkg.sv
package pd_wake_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE  = 3'd0,
    ST_PD      = 3'd1,
    ST_RESTART = 3'd2,
    ST_WINDOW  = 3'd3,
    ST_RST_REQ = 3'd4
  } pw_state_e;

  localparam logic [1:0] PH_ACTIVE  = 2'd0;
  localparam logic [1:0] PH_PD      = 2'd1;
  localparam logic [1:0] PH_RESTART = 2'd2;
endpackage

// File: rtl/pw_irq_qual.sv
module pw_irq_qual #(
  parameter int N_IRQ = 2
) (
  input  logic [N_IRQ-1:0] irq_ni,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic [N_IRQ-1:0] irq_edge_i,
  output logic [N_IRQ-1:0] wake_o,
  output logic             any_o
);
  // only enabled, level-mode, asserted lines may wake
  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    assign wake_o[i] = irq_en_i[i] & ~irq_edge_i[i] & ~irq_ni[i];
  end

  assign any_o = |wake_o;

  always_comb begin
    AST_EDGE_LINE_MASKED: assert ((wake_o & irq_edge_i) == '0); // R4
  end
endmodule

// File: rtl/pw_timer.sv
module pw_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  // load restarts at zero; count saturates on LAST so done holds
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= LAST;
    else if (load_i)         cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LAST);

  AST_TMR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R5
endmodule

// File: rtl/pd_wake_ctrl.sv
module pd_wake_ctrl
  import pd_wake_pkg::*;
#(
  parameter int N_IRQ          = 2,
  parameter int STAB_CYCLES    = 1024,
  parameter int WIN_CYCLES     = 4,
  parameter int RST_MIN_CYCLES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_set_i,
  input  logic [N_IRQ-1:0] irq_ni,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic [N_IRQ-1:0] irq_edge_i,
  input  logic             rst_pin_i,
  input  logic             osc_stable_i,
  output logic             pd_bit_o,
  output logic [1:0]       phase_o,
  output logic             osc_en_o,
  output logic             clk_en_o,
  output logic             cpu_resume_o,
  output logic             rst_req_o,
  output logic             ram_block_o
);
  pw_state_e       state_q, state_d;
  logic            pd_q;
  logic            rst_wake_q, rst_wake_d;
  logic            irq_hold_q, irq_hold_d;
  logic [N_IRQ-1:0] wake_vec;
  logic            any_wake;
  logic            stab_load, stab_done;
  logic            win_load, win_done;
  logic            hold_load, hold_done;
  logic            rst_wake_now;

  pw_irq_qual #(.N_IRQ(N_IRQ)) u_qual (
    .irq_ni    (irq_ni),
    .irq_en_i  (irq_en_i),
    .irq_edge_i(irq_edge_i),
    .wake_o    (wake_vec),
    .any_o     (any_wake)
  );

  pw_timer #(.LIMIT(STAB_CYCLES)) u_stab (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(stab_load), .done_o(stab_done)
  );

  pw_timer #(.LIMIT(WIN_CYCLES)) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(win_load), .done_o(win_done)
  );

  pw_timer #(.LIMIT(RST_MIN_CYCLES)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(hold_load), .done_o(hold_done)
  );

  // power-down bit: reset pin clears it without a clock edge
  always_ff @(posedge clk_i or negedge rst_ni or posedge rst_pin_i) begin
    if (!rst_ni)                                pd_q <= 1'b0;
    else if (rst_pin_i)                         pd_q <= 1'b0;
    else if (state_q == ST_ACTIVE && pd_set_i)  pd_q <= 1'b1;
    else if (state_q == ST_PD && any_wake)      pd_q <= 1'b0;
  end

  // a cleared bit while still in PD means the pin pulsed between edges
  assign rst_wake_now = rst_pin_i || !pd_q;

  always_comb begin
    state_d    = state_q;
    stab_load  = 1'b0;
    win_load   = 1'b0;
    hold_load  = 1'b0;
    rst_wake_d = rst_wake_q;
    irq_hold_d = irq_hold_q;
    unique case (state_q)
      ST_ACTIVE: begin
        if (pd_set_i) state_d = ST_PD;
        if (!any_wake) irq_hold_d = 1'b0;
      end
      ST_PD: begin
        if (rst_wake_now) begin
          state_d    = ST_RESTART;
          stab_load  = 1'b1;
          rst_wake_d = 1'b1;
          irq_hold_d = 1'b0;
        end else if (any_wake) begin
          state_d    = ST_RESTART;
          stab_load  = 1'b1;
          irq_hold_d = 1'b1;
        end
      end
      ST_RESTART: begin
        if (rst_pin_i) rst_wake_d = 1'b1;
        irq_hold_d = !(rst_wake_q || rst_pin_i) && any_wake;
        if (stab_done && osc_stable_i) begin
          if (rst_wake_q || rst_pin_i) begin
            state_d  = ST_WINDOW;
            win_load = 1'b1;
          end else begin
            state_d  = ST_ACTIVE;
          end
        end
      end
      ST_WINDOW: begin
        if (win_done) begin
          state_d   = ST_RST_REQ;
          hold_load = 1'b1;
        end
      end
      ST_RST_REQ: begin
        if (hold_done && !rst_pin_i) begin
          state_d    = ST_ACTIVE;
          rst_wake_d = 1'b0;
        end
      end
      default: state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_ACTIVE;
      rst_wake_q <= 1'b0;
      irq_hold_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      rst_wake_q <= rst_wake_d;
      irq_hold_q <= irq_hold_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_PD:      phase_o = PH_PD;
      ST_RESTART: phase_o = PH_RESTART;
      default:    phase_o = PH_ACTIVE;
    endcase
  end

  assign pd_bit_o     = pd_q;
  assign osc_en_o     = !pd_q;
  assign clk_en_o     = (state_q != ST_PD) && (state_q != ST_RESTART);
  assign cpu_resume_o = (state_q == ST_ACTIVE && !irq_hold_q) || (state_q == ST_WINDOW);
  assign rst_req_o    = (state_q == ST_RST_REQ);
  assign ram_block_o  = rst_wake_q;

  AST_PD_ONLY_IN_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_q |-> (state_q == ST_PD)); // R2
  AST_NO_FALSE_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PD && pd_q && !rst_pin_i && !any_wake) |=> (state_q == ST_PD)); // R4
  AST_RESUME_AFTER_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cpu_resume_o) && !ram_block_o && !$past(rst_req_o)) |-> !$past(any_wake)); // R6
  AST_IRQ_RAM_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_hold_q |-> !ram_block_o); // R7
  AST_PIN_CLEARS_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pin_i |-> !pd_q); // R8
  AST_RST_REQ_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rst_req_o) && (RST_MIN_CYCLES > 1)) |=> rst_req_o); // R10
  AST_RST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PD && rst_pin_i) |=> rst_wake_q); // R12
endmodule

// File: tb/sim_pd_wake_ctrl.sv
module sim_pd_wake_ctrl;
  localparam int STAB = 8;
  localparam int WIN  = 4;
  localparam int RMIN = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pd_set = 1'b0;
  logic [1:0] irq_n = 2'b11;
  logic [1:0] irq_en = 2'b00;
  logic [1:0] irq_edge = 2'b00;
  logic       rst_pin = 1'b0;
  logic       osc_ok = 1'b1;
  logic       pd_bit, osc_en, clk_en, resume, rst_req, ram_block;
  logic [1:0] phase;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pd_wake_ctrl #(.N_IRQ(2), .STAB_CYCLES(STAB), .WIN_CYCLES(WIN), .RST_MIN_CYCLES(RMIN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pd_set_i(pd_set), .irq_ni(irq_n), .irq_en_i(irq_en),
    .irq_edge_i(irq_edge), .rst_pin_i(rst_pin), .osc_stable_i(osc_ok), .pd_bit_o(pd_bit),
    .phase_o(phase), .osc_en_o(osc_en), .clk_en_o(clk_en), .cpu_resume_o(resume),
    .rst_req_o(rst_req), .ram_block_o(ram_block)
  );

  // fields: [6:5] enable, [4:3] edge mode, [2:1] line levels, [0] wake expected
  localparam logic [6:0] VEC [8] = '{
    7'b01_00_10_1, 7'b10_00_01_1, 7'b00_00_00_0, 7'b11_11_00_0,
    7'b01_01_10_0, 7'b10_00_10_0, 7'b11_01_00_1, 7'b11_00_11_0
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic enter_pd();
    pd_set = 1'b1;
    tick();
    pd_set = 1'b0;
    chk("R2 phase", phase, 1);
    chk("R2 pd_bit", pd_bit, 1);
    chk("R2 osc_en", osc_en, 0);
    chk("R2 clk_en", clk_en, 0);
    chk("R2 resume", resume, 0);
  endtask

  // run until fully active with no reset sequence in flight
  task automatic settle();
    int k = 0;
    irq_n = 2'b11;
    rst_pin = 1'b0;
    osc_ok = 1'b1;
    while (!(phase == 0 && !rst_req && !ram_block && resume) && k < 100) begin
      tick();
      k++;
    end
    chk("settle", int'(k < 100), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #12 rst_n = 1'b1;
    #1;
    chk("R1 pd_bit", pd_bit, 0);
    chk("R1 osc_en", osc_en, 1);
    chk("R1 clk_en", clk_en, 1);
    chk("R1 resume", resume, 1);
    chk("R1 rst_req", rst_req, 0);
    chk("R1 ram_block", ram_block, 0);
    chk("R1 phase", phase, 0);
    tick();

    // table walk: wake qualification (R3 / R4)
    for (int i = 0; i < 8; i++) begin
      enter_pd();
      irq_en = VEC[i][6:5];
      irq_edge = VEC[i][4:3];
      irq_n = VEC[i][2:1];
      tick();
      if (VEC[i][0]) begin
        chk("R3 phase", phase, 2);
        chk("R3 pd_bit", pd_bit, 0);
        chk("R3 osc_en", osc_en, 1);
        chk("R3 clk_en", clk_en, 0);
      end else begin
        chk("R4 phase", phase, 1);
        chk("R4 pd_bit", pd_bit, 1);
        irq_en = 2'b01;
        irq_edge = 2'b00;
        irq_n = 2'b10;
        tick();
      end
      settle();
      chk("R7 ram_block", ram_block, 0);
    end

    // R5 / R6: exact restart length, oscillator stall, release after entry
    enter_pd();
    irq_en = 2'b10;
    irq_edge = 2'b00;
    irq_n = 2'b01;
    tick();
    osc_ok = 1'b0;
    repeat (STAB - 1) tick();
    chk("R5 restart length", phase, 2);
    tick();
    chk("R5 waits for osc", phase, 2);
    pd_set = 1'b1;
    tick();
    pd_set = 1'b0;
    chk("R13 pd ignored", pd_bit, 0);
    osc_ok = 1'b1;
    tick();
    chk("R5 active", phase, 0);
    chk("R5 clk_en", clk_en, 1);
    chk("R6 held", resume, 0);
    chk("R7 ram open", ram_block, 0);
    tick();
    chk("R6 still held", resume, 0);
    irq_n = 2'b11;
    tick();
    chk("R6 released", resume, 1);

    // R5 exact with stable oscillator, release during restart
    enter_pd();
    irq_en = 2'b01;
    irq_n = 2'b10;
    tick();
    irq_n = 2'b11;
    repeat (STAB - 1) tick();
    chk("R5 last restart cycle", phase, 2);
    tick();
    chk("R5 exit", phase, 0);
    chk("R6 early release", resume, 1);

    // R11: pending level at the time of the write
    irq_en = 2'b01;
    irq_n = 2'b10;
    pd_set = 1'b1;
    tick();
    pd_set = 1'b0;
    chk("R11 one pd cycle", phase, 1);
    tick();
    chk("R11 restart", phase, 2);
    settle();

    // R8 / R9 / R10: reset wake
    irq_en = 2'b00;
    enter_pd();
    rst_pin = 1'b1;
    #1;
    chk("R8 async pd clear", pd_bit, 0);
    chk("R8 async osc_en", osc_en, 1);
    tick();
    chk("R9 restart", phase, 2);
    chk("R9 ram_block", ram_block, 1);
    rst_pin = 1'b0;
    repeat (STAB - 1) tick();
    chk("R9 restart length", phase, 2);
    tick();
    chk("R9 window resume", resume, 1);
    chk("R9 window ram", ram_block, 1);
    chk("R9 window no req", rst_req, 0);
    repeat (WIN - 1) tick();
    chk("R9 window end", rst_req, 0);
    tick();
    chk("R9 req rises", rst_req, 1);
    chk("R9 cpu stops", resume, 0);
    tick();
    chk("R10 min hold", rst_req, 1);
    tick();
    chk("R10 req falls", rst_req, 0);
    chk("R10 ram open", ram_block, 0);
    chk("R10 resume", resume, 1);

    // R10: pin held through the request
    enter_pd();
    rst_pin = 1'b1;
    tick();
    repeat (STAB + WIN) tick();
    chk("R10 req up", rst_req, 1);
    repeat (4) tick();
    chk("R10 held by pin", rst_req, 1);
    rst_pin = 1'b0;
    tick();
    chk("R10 released", rst_req, 0);

    // R12: tie between pin and interrupt
    enter_pd();
    irq_en = 2'b01;
    irq_n = 2'b10;
    rst_pin = 1'b1;
    tick();
    chk("R12 reset path", ram_block, 1);
    chk("R12 phase", phase, 2);
    settle();
    chk("R12 done", ram_block, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule